// File: doc/BRIEF.md
# Dual-Channel Interleaved PWM Sequencer

This block decides, cycle by cycle, when each of two power-stage channels turns its high-side switch on and when it hands over to the low-side switch. A new switching cycle is started by a timing event. Successive events go to channel 1 and channel 2 in turn, so the two channels run half a period apart. The events come either from an internal oscillator tick or, when one is present, from falling edges on an external SYNC pin. A cycle ends when the same channel receives its next start event.

Inside a cycle, the high side turns on after a programmable dead time. It stays on until the channel's peak-current comparator or overcurrent comparator trips, or until the cycle ends. After a trip, a second dead time follows and then the low side conducts for the rest of the cycle. The external sync path has a two-flop synchronizer, falling-edge detection and a timeout that returns control to the internal tick. The block also outputs a forced-PWM status bit that records, at each cycle start, whether SYNC is held high. The comparators themselves are analog and are outside the block; their results arrive here as digital inputs.

Top module: `pwm_interleave_seq`

## Requirements
- R1: While reset is low, and directly after it is released, every high-side enable, every low-side enable and `fpwm_o` is 0.
- R2: In internal mode, successive `osc_tick_i` pulses start channel 1 (bit 0), then channel 2 (bit 1), alternating, beginning with channel 1 after reset. The started channel's high-side enable rises exactly `dt_cycles_i`+2 clock cycles after the edge that samples the tick.
- R3: A peak trip sampled while the high side is on drops the high side at that edge. The low side then rises `dt_cycles_i`+1 cycles later.
- R4: A start event for a channel drops its low-side enable, or its high-side enable if no trip came (maximum duty), one cycle after the edge that samples the tick. A start for the other channel leaves it unchanged.
- R5: An asserted overcurrent trip forces that channel's high-side enable low in the same cycle. The high side stays off until the channel's next start event, and the low side follows after the dead time.
- R6: A channel's two enables are never high together. An enable rises only after the complementary enable has been low for at least `dt_cycles_i`+1 cycles.
- R7: The first synchronized falling edge of `sync_i` seen in internal mode always starts channel 1 and switches the block to external mode. Later falling edges alternate between the channels, and `osc_tick_i` is ignored in external mode. The high side rises `dt_cycles_i`+4 cycles after the edge that first samples `sync_i` low.
- R8: If no falling edge is detected for `TO_CYC` cycles, the block returns to internal mode, and `osc_tick_i` starts cycles again.
- R9: At each start event `fpwm_o` takes the value 1 if synchronized `sync_i` is high and the block is in internal mode, and 0 otherwise. Between start events `fpwm_o` holds its value.
- R10: A peak trip that arrives while the high side is off has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | Internal oscillator tick, one pulse per half period |
| sync_i | input | 1 | External sync pin, asynchronous |
| dt_cycles_i | input | DT_W | Dead time setting; the gap is this value plus one cycle |
| peak_trip_i | input | 2 | Peak-current comparator trip per channel, bit 0 = channel 1 |
| oc_trip_i | input | 2 | Overcurrent comparator trip per channel |
| hs_en_o | output | 2 | High-side switch enable per channel |
| ls_en_o | output | 2 | Low-side switch enable per channel |
| fpwm_o | output | 1 | Forced-PWM status, updated at cycle starts |

## Verification
The assertions check, on every cycle, the local rules:
- at most one start pulse is issued at a time;
- no tick leaks through in external mode;
- a first falling edge is routed to channel 1;
- after an overcurrent or peak trip the high side is off;
- a start clears both enables;
- each enable rises only after the complementary one was low;
- `fpwm_o` changes only on a start.

Only the bench scenarios can show the exact rise latencies for each dead-time setting, the alternation order across mode changes, the timeout back to internal mode, and that trips arriving while the high side is off are ignored.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DT_HS,
    PH_HS,
    PH_DT_LS,
    PH_LS
  } phase_e;

endpackage

// File: rtl/pwm_sync_front.sv
module pwm_sync_front #(
  parameter int TO_CYC = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic fall_o,
  output logic ext_mode_o,
  output logic sync_lvl_o
);

  localparam int TO_W = (TO_CYC > 1) ? $clog2(TO_CYC) : 1;

  logic s1_q, s2_q, s3_q;
  logic ext_q;
  logic [TO_W-1:0] to_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= sync_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o     = s3_q & ~s2_q;
  assign sync_lvl_o = s2_q;
  assign ext_mode_o = ext_q;

  // external mode expires after TO_CYC cycles without a falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q    <= 1'b0;
      to_cnt_q <= '0;
    end else if (fall_o) begin
      ext_q    <= 1'b1;
      to_cnt_q <= '0;
    end else if (ext_q) begin
      if (to_cnt_q == TO_W'(TO_CYC - 1)) begin
        ext_q    <= 1'b0;
        to_cnt_q <= '0;
      end else begin
        to_cnt_q <= to_cnt_q + 1'b1;
      end
    end
  end

  p_ext_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> ext_mode_o);

endmodule

// File: rtl/pwm_phase_steer.sv
module pwm_phase_steer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_tick_i,
  input  logic       fall_i,
  input  logic       ext_mode_i,
  input  logic       sync_lvl_i,
  output logic [1:0] start_o,
  output logic       fpwm_o
);

  logic [1:0] start_q;
  logic       sel_q;
  logic       fpwm_q;
  logic       tgt;

  // first edge after internal mode always goes to channel 1
  always_comb tgt = (fall_i && !ext_mode_i) ? 1'b0 : sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      sel_q   <= 1'b0;
      fpwm_q  <= 1'b0;
    end else begin
      start_q <= '0;
      if (fall_i) begin
        start_q[tgt] <= 1'b1;
        sel_q        <= ~tgt;
        fpwm_q       <= sync_lvl_i & ~ext_mode_i;
      end else if (osc_tick_i && !ext_mode_i) begin
        start_q[sel_q] <= 1'b1;
        sel_q          <= ~sel_q;
        fpwm_q         <= sync_lvl_i;
      end
    end
  end

  assign start_o = start_q;
  assign fpwm_o  = fpwm_q;

  p_one_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_q));

  p_tick_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && !fall_i) |=> (start_q == 2'b00));

  p_first_fall_ch1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !ext_mode_i) |=> (start_q == 2'b01));

  p_fpwm_at_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fpwm_q) |-> (start_q != 2'b00));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_seq_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            peak_trip_i,
  input  logic            oc_trip_i,
  input  logic [DT_W-1:0] dt_cycles_i,
  output logic            hs_en_o,
  output logic            ls_en_o
);

  phase_e          st_q, st_d;
  logic [DT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PH_DT_HS: begin
        if (oc_trip_i) begin
          st_d  = PH_DT_LS;
          cnt_d = '0;
        end else if (cnt_q >= dt_cycles_i) begin
          st_d = PH_HS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HS: begin
        if (oc_trip_i || peak_trip_i) begin
          st_d  = PH_DT_LS;
          cnt_d = '0;
        end
      end
      PH_DT_LS: begin
        if (cnt_q >= dt_cycles_i) st_d = PH_LS;
        else                      cnt_d = cnt_q + 1'b1;
      end
      default: ;
    endcase
    // cycle boundary overrides everything, including max-duty cutoff
    if (start_i) begin
      st_d  = PH_DT_HS;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // overcurrent kills the high side without waiting for a clock edge
  assign hs_en_o = (st_q == PH_HS) & ~oc_trip_i;
  assign ls_en_o = (st_q == PH_LS);

  p_oc_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_trip_i && !start_i) |=> !hs_en_o);

  p_peak_handover_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_o && peak_trip_i && !start_i) |=> !hs_en_o);

  p_start_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!hs_en_o && !ls_en_o));

  p_ls_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> !$past(hs_en_o));

  p_hs_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> !$past(ls_en_o));

endmodule

// File: rtl/pwm_interleave_seq.sv
module pwm_interleave_seq
  import pwm_seq_pkg::*;
#(
  parameter int DT_W   = 4,
  parameter int TO_CYC = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                osc_tick_i,
  input  logic                sync_i,
  input  logic [DT_W-1:0]     dt_cycles_i,
  input  logic [NUM_CH-1:0]   peak_trip_i,
  input  logic [NUM_CH-1:0]   oc_trip_i,
  output logic [NUM_CH-1:0]   hs_en_o,
  output logic [NUM_CH-1:0]   ls_en_o,
  output logic                fpwm_o
);

  logic              fall;
  logic              ext_mode;
  logic              sync_lvl;
  logic [NUM_CH-1:0] start;

  pwm_sync_front #(
    .TO_CYC(TO_CYC)
  ) i_sync_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .fall_o     (fall),
    .ext_mode_o (ext_mode),
    .sync_lvl_o (sync_lvl)
  );

  pwm_phase_steer i_phase_steer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .fall_i     (fall),
    .ext_mode_i (ext_mode),
    .sync_lvl_i (sync_lvl),
    .start_o    (start),
    .fpwm_o     (fpwm_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pwm_chan #(
      .DT_W(DT_W)
    ) i_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start[g]),
      .peak_trip_i (peak_trip_i[g]),
      .oc_trip_i   (oc_trip_i[g]),
      .dt_cycles_i (dt_cycles_i),
      .hs_en_o     (hs_en_o[g]),
      .ls_en_o     (ls_en_o[g])
    );
  end

endmodule

// File: tb/test_pwm_interleave_seq.sv
module test_pwm_interleave_seq;

  localparam int DT_W   = 4;
  localparam int TO_CYC = 256;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            osc_tick_i = 1'b0;
  logic            sync_i = 1'b0;
  logic [DT_W-1:0] dt_cycles_i = 4'd2;
  logic [1:0]      peak_trip_i = '0;
  logic [1:0]      oc_trip_i = '0;
  logic [1:0]      hs_en_o, ls_en_o;
  logic            fpwm_o;

  int n_chk  = 0;
  int n_fail = 0;
  int ovl_err = 0;
  int gap_err = 0;
  int since_hs [2] = '{100, 100};
  int since_ls [2] = '{100, 100};
  logic [1:0] hs_prev = '0, ls_prev = '0;

  always #2 clk_i = ~clk_i;

  pwm_interleave_seq #(.DT_W(DT_W), .TO_CYC(TO_CYC)) i_pwm_interleave_seq (
    .clk_i, .rst_ni, .osc_tick_i, .sync_i, .dt_cycles_i,
    .peak_trip_i, .oc_trip_i, .hs_en_o, .ls_en_o, .fpwm_o
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic osc_pulse();
    osc_tick_i = 1'b1;
    step(1);
    osc_tick_i = 1'b0;
  endtask

  task automatic sync_fall();
    sync_i = 1'b1;
    step(6);
    sync_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // R6 monitor: overlap and dead-gap, sampled between edges after drives
  always @(negedge clk_i) begin
    #1;
    if (rst_ni) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (hs_en_o[ch] && ls_en_o[ch]) ovl_err++;
        if (ls_en_o[ch] && !ls_prev[ch] && since_hs[ch] < int'(dt_cycles_i) + 1) gap_err++;
        if (hs_en_o[ch] && !hs_prev[ch] && since_ls[ch] < int'(dt_cycles_i) + 1) gap_err++;
        since_hs[ch] = hs_en_o[ch] ? 0 : ((since_hs[ch] < 100) ? since_hs[ch] + 1 : 100);
        since_ls[ch] = ls_en_o[ch] ? 0 : ((since_ls[ch] < 100) ? since_ls[ch] + 1 : 100);
      end
      hs_prev = hs_en_o;
      ls_prev = ls_en_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int dt;
    int sel_m;
    int cyc;
    int gap;
    int due [2];
    bit pend [2];
    void'($urandom(32'h1234_5a5a));
    dt = 2;

    // R1 reset
    step(3);
    chk("R1 hs in reset", hs_en_o, 0);
    chk("R1 ls in reset", ls_en_o, 0);
    chk("R1 fpwm in reset", fpwm_o, 0);
    rst_ni = 1'b1;
    step(2);
    chk("R1 hs after reset", hs_en_o, 0);
    chk("R1 ls after reset", ls_en_o, 0);

    // R2 first tick -> channel 1
    osc_pulse();
    step(1 + dt);
    chk("R2 ch1 hs before latency", hs_en_o[0], 0);
    step(1);
    chk("R2 ch1 hs at dt+2", hs_en_o[0], 1);
    chk("R2 ch2 untouched", hs_en_o[1], 0);

    // R3 peak trip hands over
    step(2);
    peak_trip_i[0] = 1'b1;
    step(1);
    peak_trip_i[0] = 1'b0;
    chk("R3 hs off after trip", hs_en_o[0], 0);
    chk("R3 ls off during dead time", ls_en_o[0], 0);
    step(dt);
    chk("R3 ls before dt+1", ls_en_o[0], 0);
    step(1);
    chk("R3 ls at dt+1", ls_en_o[0], 1);

    // R10 trip while high side off
    peak_trip_i[0] = 1'b1;
    step(1);
    peak_trip_i[0] = 1'b0;
    step(3);
    chk("R10 ls kept", ls_en_o[0], 1);
    chk("R10 hs kept off", hs_en_o[0], 0);

    // R2 second tick -> channel 2
    osc_pulse();
    step(1 + dt);
    chk("R2 ch2 hs before latency", hs_en_o[1], 0);
    step(1);
    chk("R2 ch2 hs at dt+2", hs_en_o[1], 1);
    chk("R4 ch1 ls unaffected by ch2 start", ls_en_o[0], 1);

    // R4 cycle end drops ls of ch1
    osc_pulse();
    chk("R4 ls still on at sample edge", ls_en_o[0], 1);
    step(1);
    chk("R4 ls off after start", ls_en_o[0], 0);
    step(dt);
    chk("R4 ch1 hs during dead time", hs_en_o[0], 0);
    step(1);
    chk("R4 ch1 hs back on", hs_en_o[0], 1);

    // R4 max duty on ch2 (no trip)
    osc_pulse();
    chk("R4 ch2 hs on at sample edge", hs_en_o[1], 1);
    step(1);
    chk("R4 ch2 hs forced off at cycle end", hs_en_o[1], 0);
    step(dt);
    chk("R4 ch2 hs in dead time", hs_en_o[1], 0);
    step(1);
    chk("R4 ch2 hs new cycle", hs_en_o[1], 1);

    // R5 overcurrent
    step(2);
    oc_trip_i[0] = 1'b1;
    #1;
    chk("R5 hs drops at once", hs_en_o[0], 0);
    step(1);
    oc_trip_i[0] = 1'b0;
    chk("R5 hs stays off", hs_en_o[0], 0);
    step(10);
    chk("R5 hs off until next start", hs_en_o[0], 0);
    chk("R5 ls follows", ls_en_o[0], 1);

    // R7 first fall -> channel 1
    sync_fall();
    step(4 + dt);
    chk("R7 ch1 hs before ext latency", hs_en_o[0], 0);
    chk("R4 ls dropped by ext start", ls_en_o[0], 0);
    step(1);
    chk("R7 ch1 hs at dt+4", hs_en_o[0], 1);

    // R7 tick ignored in external mode
    osc_pulse();
    step(8);
    chk("R7 ch2 ignores tick", hs_en_o[1], 1);
    chk("R7 ch1 ignores tick", hs_en_o[0], 1);

    // R7 second fall -> channel 2
    sync_fall();
    step(3);
    chk("R7 ch2 hs before start", hs_en_o[1], 1);
    step(1);
    chk("R7 ch2 cycle end", hs_en_o[1], 0);
    step(dt);
    step(1);
    chk("R7 ch2 hs second fall", hs_en_o[1], 1);
    chk("R7 ch1 untouched by second fall", hs_en_o[0], 1);
    chk("R9 fpwm low in ext mode", fpwm_o, 0);

    // R7 third fall -> channel 1
    sync_fall();
    step(3);
    chk("R7 ch1 hs before third start", hs_en_o[0], 1);
    step(1);
    chk("R7 ch1 cycle end on third fall", hs_en_o[0], 0);
    step(dt + 1);
    chk("R7 ch1 hs third fall", hs_en_o[0], 1);

    // R8 timeout back to internal, R9 forced pwm
    sync_i = 1'b1;
    step(TO_CYC + 10);
    chk("R9 fpwm unchanged without start", fpwm_o, 0);
    osc_pulse();
    chk("R9 fpwm set at start", fpwm_o, 1);
    step(1);
    chk("R8 tick restarts ch2", hs_en_o[1], 0);
    step(dt);
    step(1);
    chk("R8 ch2 hs after timeout", hs_en_o[1], 1);
    osc_pulse();
    step(2 + dt);
    chk("R8 ch1 hs after tick", hs_en_o[0], 1);
    chk("R9 fpwm held", fpwm_o, 1);

    // R7 first fall after internal goes to ch1 even when ch2 is next
    sync_i = 1'b0;
    step(2);
    chk("R9 fpwm before fall start", fpwm_o, 1);
    step(1);
    chk("R9 fpwm cleared at fall start", fpwm_o, 0);
    step(1);
    chk("R7 first fall hits ch1", hs_en_o[0], 0);
    chk("R7 first fall spares ch2", hs_en_o[1], 1);
    step(dt + 1);
    chk("R7 ch1 hs after first fall", hs_en_o[0], 1);

    // random phase, internal mode
    step(TO_CYC + 10);
    sel_m = 1;
    cyc = 0;
    gap = 100;
    for (int seg = 0; seg < 4; seg++) begin
      peak_trip_i = '0;
      oc_trip_i = '0;
      step(20);
      dt = $urandom_range(0, 5);
      dt_cycles_i = DT_W'(dt);
      step(10);
      pend[0] = 0;
      pend[1] = 0;
      for (int c = 0; c < 600; c++) begin
        for (int ch = 0; ch < 2; ch++) begin
          if (pend[ch] && cyc == due[ch] - 1)
            chk("R2 random hs low before due", hs_en_o[ch], 0);
          if (pend[ch] && cyc == due[ch]) begin
            chk("R2 random hs rise on due", hs_en_o[ch], 1);
            pend[ch] = 0;
          end
        end
        osc_tick_i = 1'b0;
        if (gap >= dt + 5 && $urandom_range(0, 11) == 0) begin
          osc_tick_i = 1'b1;
          pend[sel_m] = 1;
          due[sel_m] = cyc + 3 + dt;
          sel_m ^= 1;
          gap = 0;
        end else begin
          gap++;
        end
        for (int ch = 0; ch < 2; ch++) begin
          peak_trip_i[ch] = ($urandom_range(0, 15) == 0);
          oc_trip_i[ch]   = !pend[ch] && ($urandom_range(0, 63) == 0);
        end
        step(1);
        cyc++;
      end
    end
    osc_tick_i = 1'b0;
    peak_trip_i = '0;
    oc_trip_i = '0;
    step(5);

    chk("R6 no overlap", ovl_err, 0);
    chk("R6 dead gap kept", gap_err, 0);
    finish_run();
  end

endmodule